// File: doc/BRIEF.md
# Non-Volatile Macro Power-Mode Sequencer

This block sits between a simple register bus and a one-time-programmable memory macro. Software requests a power mode by writing the mode register. The block accepts a request only when it names a neighbouring mode of the current one. It then starts the change on the macro and reports completion with a sticky status bit. Each kind of change has its own bit. To go from the lowest mode to active, software makes two requests and passes through standby. Going back down also takes two requests.

A single-word read is made from active mode. Software loads a word address and a transfer count of one, then requests the read mode. When the macro returns the word, the block stores it in a read-data register, sets the read-done status bit and falls back to active. A busy output is high while a change or a read is in flight. A behavioural macro model inside the block supplies the per-operation latency and a computed memory content.

Top module: `nvm_pwr_seq`

## Requirements
- R1: After reset the mode reads 0, the status and read-data registers read 0 and busy is low.
- R2: The mode encodings are 0 = deepest sleep, 1 = standby, 2 = active and 3 = read. A mode-register write (word index 0) whose value is adjacent to the current mode is accepted: the mode register reads the new value and busy is high from the cycle after the write.
- R3: Completing deepest sleep to standby sets status bit 8. Completing standby to active sets status bit 7.
- R4: Completing active to standby sets status bit 9. Completing standby to deepest sleep sets status bit 10.
- R5: A mode write that is not adjacent, that names the current mode, or that has any of bits 31:2 set is ignored. The mode keeps its value, busy stays low and no status bit is set.
- R6: For a power change, busy stays high for exactly PWR_LAT+1 cycles. For a read, busy stays high for exactly READ_LAT+1 cycles.
- R7: A mode write made while busy is high is dropped. The change in flight completes alone and sets only its own bit.
- R8: A read request from active with transfer count 1 sets status bit 0 on completion. The mode then returns to 2, and the read-data register holds ((A * 32'h01000193) ^ 32'hC0DE0000) mod 2^32, where A is the word address.
- R9: A read request made while not active, or with a transfer count other than 1, is ignored. The mode, status and read-data register are left unchanged.
- R10: A status write (word index 1) clears each bit written as 1 and keeps each bit written as 0.
- R11: The word indices are 0 mode, 1 status, 2 word address, 3 transfer count and 4 read data. Any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| busy | output | 1 | A power change or read is in flight |

## Verification
The assertions assume that the bus makes at most one access per cycle and that its inputs settle well before each rising edge. The bench drives the bus on falling edges so that this holds. They also assume that both latencies are at least one, and the stimulus never chains requests faster than the busy flag allows except where dropped writes are being tested on purpose. Status and read-data are compared only once busy has fallen. A read-back of a register never coincides with a write to it.

// File: rtl/nvm_pwr_pkg.sv
package nvm_pwr_pkg;

  typedef enum logic [1:0] {
    MD_DEEP = 2'd0,
    MD_STBY = 2'd1,
    MD_ACT  = 2'd2,
    MD_READ = 2'd3
  } md_e;

  localparam int ST_W   = 11;
  localparam int ST_RD  = 0;
  localparam int ST_S2A = 7;
  localparam int ST_D2S = 8;
  localparam int ST_A2S = 9;
  localparam int ST_S2D = 10;

  localparam int IDX_W    = 3;
  localparam int IDX_MODE = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ADDR = 2;
  localparam int IDX_CNT  = 3;
  localparam int IDX_RDAT = 4;

  // Is the step from 'cur' to 'nxt' a legal single move?
  function automatic logic legal_step(md_e cur, md_e nxt, logic cnt_ok);
    logic ok;
    case (cur)
      MD_DEEP: ok = (nxt == MD_STBY);
      MD_STBY: ok = (nxt == MD_DEEP) || (nxt == MD_ACT);
      MD_ACT:  ok = (nxt == MD_STBY) || ((nxt == MD_READ) && cnt_ok);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Status bit raised when the step from 'cur' to 'nxt' completes
  function automatic logic [ST_W-1:0] done_mask(md_e cur, md_e nxt);
    logic [ST_W-1:0] m;
    m = '0;
    if (cur == MD_DEEP && nxt == MD_STBY) m[ST_D2S] = 1'b1;
    if (cur == MD_STBY && nxt == MD_ACT)  m[ST_S2A] = 1'b1;
    if (cur == MD_ACT  && nxt == MD_STBY) m[ST_A2S] = 1'b1;
    if (cur == MD_STBY && nxt == MD_DEEP) m[ST_S2D] = 1'b1;
    if (cur == MD_ACT  && nxt == MD_READ) m[ST_RD]  = 1'b1;
    return m;
  endfunction

  // Behavioural memory content of the macro
  function automatic logic [31:0] word_at(logic [31:0] a);
    return (a * 32'h01000193) ^ 32'hC0DE0000;
  endfunction

endpackage

// File: rtl/nvm_pwr_macro.sv
module nvm_pwr_macro
  import nvm_pwr_pkg::*;
#(
  parameter int PWR_LAT  = 6,
  parameter int READ_LAT = 3,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  md_e           tgt_i,
  input  logic [AW-1:0] addr_i,
  output logic          done_o,
  output logic [31:0]   rdata_o
);

  localparam int MAX_LAT = (PWR_LAT > READ_LAT) ? PWR_LAT : READ_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  md_e              tgt_q;
  md_e              mac_mode_q;
  logic [AW-1:0]    addr_q;
  logic             is_read;

  assign is_read = (tgt_q == MD_READ);
  assign done_o  = (cnt_q == CNT_W'(1));
  assign rdata_o = (done_o && is_read) ? word_at(32'(addr_q)) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tgt_q      <= MD_DEEP;
      mac_mode_q <= MD_DEEP;
      addr_q     <= '0;
    end else if (start_i) begin
      tgt_q  <= tgt_i;
      addr_q <= addr_i;
      cnt_q  <= (tgt_i == MD_READ) ? CNT_W'(READ_LAT) : CNT_W'(PWR_LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (done_o && !is_read) mac_mode_q <= tgt_q;
    end
  end

  initial begin
    assert_lat_min_R6: assert (PWR_LAT >= 1 && READ_LAT >= 1);
  end

  // A new operation starts only when the macro is idle (R7)
  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_q == '0));

  // The macro is only read while it sits in active mode (R8)
  assert_read_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && tgt_i == MD_READ) |-> (mac_mode_q == MD_ACT));

endmodule

// File: rtl/nvm_pwr_ctl.sv
module nvm_pwr_ctl
  import nvm_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr_i,
  input  logic [31:0]     mode_val_i,
  input  logic            cnt_ok_i,
  input  logic            mac_done_i,
  output md_e             mode_o,
  output logic            busy_o,
  output logic            start_o,
  output logic [ST_W-1:0] set_o,
  output logic            rd_load_o
);

  md_e  mode_q, from_q;
  logic busy_q, start_q;
  md_e  req_mode;
  logic req_clean;
  logic accept;
  logic finish;

  assign req_mode  = md_e'(mode_val_i[1:0]);
  assign req_clean = (mode_val_i[31:2] == '0);
  assign accept    = mode_wr_i && !busy_q && req_clean &&
                     legal_step(mode_q, req_mode, cnt_ok_i);
  assign finish    = busy_q && mac_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_DEEP;
      from_q  <= MD_DEEP;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        from_q <= mode_q;
        mode_q <= req_mode;
        busy_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        if (mode_q == MD_READ) mode_q <= MD_ACT;
      end
    end
  end

  assign mode_o    = mode_q;
  assign busy_o    = busy_q;
  assign start_o   = start_q;
  assign set_o     = finish ? done_mask(from_q, mode_q) : '0;
  assign rd_load_o = finish && (mode_q == MD_READ);

  // Mode only ever moves by one encoding step (R2)
  assert_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |->
      ((int'(mode_q) - int'($past(mode_q)) == 1) ||
       (int'($past(mode_q)) - int'(mode_q) == 1)));

  // Mode is frozen while an operation is in flight (R7)
  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mac_done_i) |=> $stable(mode_q));

  // A finished read lands back in active (R8)
  assert_read_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && mode_q == MD_READ) |=> (mode_q == MD_ACT && !busy_q));

  // Completion raises exactly one status bit (R3)
  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> $onehot(set_o));

endmodule

// File: rtl/nvm_pwr_regs.sv
module nvm_pwr_regs
  import nvm_pwr_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  md_e              mode_i,
  input  logic [ST_W-1:0]  set_i,
  input  logic             rd_load_i,
  input  logic [31:0]      rd_word_i,
  output logic             mode_wr_o,
  output logic [AW-1:0]    addr_o,
  output logic             cnt_ok_o
);

  logic [ST_W-1:0] stat_q;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt_q;
  logic [31:0]     rdat_q;
  logic            wr_en;
  logic            stat_clr_en;
  logic [ST_W-1:0] clr_mask;

  assign wr_en       = bus_sel && bus_wr;
  assign stat_clr_en = wr_en && (bus_idx == IDX_W'(IDX_STAT));
  assign clr_mask    = stat_clr_en ? bus_wdata[ST_W-1:0] : '0;
  assign mode_wr_o   = wr_en && (bus_idx == IDX_W'(IDX_MODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      rdat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_i;
      if (wr_en && bus_idx == IDX_W'(IDX_ADDR)) addr_q <= bus_wdata[AW-1:0];
      if (wr_en && bus_idx == IDX_W'(IDX_CNT))  cnt_q  <= bus_wdata[CW-1:0];
      if (rd_load_i) rdat_q <= rd_word_i;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_idx)
        IDX_W'(IDX_MODE): bus_rdata = {30'd0, mode_i};
        IDX_W'(IDX_STAT): bus_rdata = 32'(stat_q);
        IDX_W'(IDX_ADDR): bus_rdata = 32'(addr_q);
        IDX_W'(IDX_CNT):  bus_rdata = 32'(cnt_q);
        IDX_W'(IDX_RDAT): bus_rdata = rdat_q;
        default:          bus_rdata = '0;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign cnt_ok_o = (cnt_q == CW'(1));

  // A status bit only falls after a status write (R10)
  assert_w1c_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~stat_q) != '0) |-> $past(stat_clr_en));

  // A status bit only rises when the sequencer reports a completion (R3)
  assert_set_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) != '0) |-> ($past(set_i) != '0));

endmodule

// File: rtl/nvm_pwr_seq.sv
module nvm_pwr_seq
  import nvm_pwr_pkg::*;
#(
  parameter int PWR_LAT  = 6,
  parameter int READ_LAT = 3,
  parameter int AW       = 10,
  parameter int CW       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy
);

  md_e             mode;
  logic [ST_W-1:0] set_vec;
  logic            rd_load;
  logic [31:0]     mac_rdata;
  logic            mode_wr;
  logic [AW-1:0]   word_addr;
  logic            cnt_ok;
  logic            mac_start;
  logic            mac_done;

  nvm_pwr_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_i    (mode),
    .set_i     (set_vec),
    .rd_load_i (rd_load),
    .rd_word_i (mac_rdata),
    .mode_wr_o (mode_wr),
    .addr_o    (word_addr),
    .cnt_ok_o  (cnt_ok)
  );

  nvm_pwr_ctl ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr_i  (mode_wr),
    .mode_val_i (bus_wdata),
    .cnt_ok_i   (cnt_ok),
    .mac_done_i (mac_done),
    .mode_o     (mode),
    .busy_o     (busy),
    .start_o    (mac_start),
    .set_o      (set_vec),
    .rd_load_o  (rd_load)
  );

  nvm_pwr_macro #(.PWR_LAT(PWR_LAT), .READ_LAT(READ_LAT), .AW(AW)) macro_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (mac_start),
    .tgt_i   (mode),
    .addr_i  (word_addr),
    .done_o  (mac_done),
    .rdata_o (mac_rdata)
  );

  // Read data only changes when a read finishes with its status bit (R8)
  assert_rdata_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> set_vec[ST_RD]);

endmodule

// File: tb/nvm_pwr_seq_tb_top.sv
module nvm_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PWR_LAT    = 6;
  localparam int READ_LAT   = 3;
  localparam int AW         = 10;
  localparam int CW         = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_pwr_seq #(.PWR_LAT(PWR_LAT), .READ_LAT(READ_LAT), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  // {write value[1:0], accepted, expected mode[1:0], expected status[10:0]}
  localparam logic [15:0] VEC [11] = '{
    {2'd2, 1'b0, 2'd0, 11'h000},  // R5 skip a mode
    {2'd3, 1'b0, 2'd0, 11'h000},  // R9 read from deepest sleep
    {2'd1, 1'b1, 2'd1, 11'h100},  // R3
    {2'd1, 1'b0, 2'd1, 11'h000},  // R5 same mode
    {2'd2, 1'b1, 2'd2, 11'h080},  // R3
    {2'd0, 1'b0, 2'd2, 11'h000},  // R5
    {2'd1, 1'b1, 2'd1, 11'h200},  // R4
    {2'd3, 1'b0, 2'd1, 11'h000},  // R9 read from standby
    {2'd0, 1'b1, 2'd0, 11'h400},  // R4
    {2'd1, 1'b1, 2'd1, 11'h100},  // R3
    {2'd2, 1'b1, 2'd2, 11'h080}   // R3
  };

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] x;
    x = 32'(a);
    return ((x << 24) + (x << 8) + (x << 7) + (x << 4) + (x << 1) + x) ^ 32'hC0DE0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(int idx, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = 3'(idx); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic br(int idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = 3'(idx);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    br(0, v); check("R1 mode", v, 32'd0);
    br(1, v); check("R1 status", v, 32'd0);
    br(4, v); check("R1 rdata", v, 32'd0);

    bw(3, 32'd1);
    for (int k = 0; k < 11; k++) begin
      logic [15:0] e;
      e = VEC[k];
      bw(0, 32'(e[15:14]));
      check(e[13] ? "R2 busy" : "R5 busy", 32'(busy), 32'(e[13]));
      br(0, v); check(e[13] ? "R2 mode" : "R5 mode", v, 32'(e[12:11]));
      wait_idle();
      br(1, v); check(e[13] ? "R3/R4 status" : "R5 status", v, 32'(e[10:0]));
      bw(1, 32'hFFFF_FFFF);
      br(1, v); check("R10 cleared", v, 32'd0);
    end

    // R5 upper bits set: mode stays active
    bw(0, 32'h0000_0005);
    check("R5 wide busy", 32'(busy), 32'd0);
    br(0, v); check("R5 wide mode", v, 32'd2);

    // R7 write during busy dropped
    bw(0, 32'd1);
    bw(0, 32'd2);
    wait_idle();
    br(0, v); check("R7 mode", v, 32'd1);
    br(1, v); check("R7 status", v, 32'h200);
    bw(1, 32'hFFFF_FFFF);

    // R6 power change busy length
    bw(0, 32'd2);
    count_busy(n);
    check("R6 power busy", 32'(n), 32'(PWR_LAT + 1));
    bw(1, 32'hFFFF_FFFF);

    // R8 read at address 5
    bw(2, 32'd5);
    bw(3, 32'd1);
    bw(0, 32'd3);
    br(0, v); check("R8 read mode", v, 32'd3);
    wait_idle();
    br(0, v); check("R8 back to active", v, 32'd2);
    br(1, v); check("R8 done bit", v, 32'h1);
    br(4, v); check("R8 rdata 5", v, exp_word(5));

    // R10 partial clear
    bw(1, 32'h0);
    br(1, v); check("R10 keep", v, 32'h1);
    bw(1, 32'h1);
    br(1, v); check("R10 clear", v, 32'h0);

    // R6 read busy length, top address
    bw(2, 32'((1 << AW) - 1));
    bw(0, 32'd3);
    count_busy(n);
    check("R6 read busy", 32'(n), 32'(READ_LAT + 1));
    br(4, v); check("R8 rdata top", v, exp_word((1 << AW) - 1));
    bw(1, 32'hFFFF_FFFF);

    // R9 transfer count 2 ignored
    bw(3, 32'd2);
    bw(0, 32'd3);
    check("R9 busy", 32'(busy), 32'd0);
    br(0, v); check("R9 mode", v, 32'd2);
    br(1, v); check("R9 status", v, 32'd0);
    br(4, v); check("R9 rdata", v, exp_word((1 << AW) - 1));

    // R11 register map
    br(2, v); check("R11 addr", v, 32'((1 << AW) - 1));
    br(3, v); check("R11 count", v, 32'd2);
    br(5, v); check("R11 unmapped", v, 32'd0);
    br(7, v); check("R11 unmapped", v, 32'd0);

    finished = 1'b1;
    summary();
  end

endmodule